// File: doc/BRIEF.md
# Periodic Interval Timer with Programmable Interrupt Number

This block is a memory-mapped timer that raises an interrupt request at a fixed interval. Software writes the interval, in bus clock periods, into the throttle register. It then writes a control word that sets the run flag and also selects the interrupt number the timer emits. While it runs, the timer counts clock periods. Each time the interval elapses it raises `irq_req` and presents the programmed number on `irq_num`. The request stays up until the interrupt controller acknowledges it.

The emitted number is not wired in. It is a 6-bit number field, and a 4-bit legacy priority field is ORed onto bits 5..2 of it. A read-only register reports the bus clock period in nanoseconds, so software can work out the tick rate. A small 12-bit countdown register sits beside the timer as an independent utility counter.

Control is a three-state machine:
- **IDLE**: stopped, no request.
- **COUNT**: running, no request pending.
- **PEND**: running, request asserted.

Transitions:
- *arm*: a control write with the run flag set goes from any state to COUNT and reloads the interval counter.
- *halt*: a control write with the run flag clear goes from any state to IDLE.
- *expire*: the interval elapsing moves COUNT to PEND. In PEND it keeps the request up.
- *retire*: an acknowledge in PEND with no new expiry moves back to COUNT.

Top module: `pit_timer`

## Requirements
- R1: After reset, `irq_req` is 0 and reads of offsets 0x00, 0x10 and 0x14 return 0.
- R2: Offset 0x00 is the control word, with run flag at bit 26, priority at bits 23:20 and number at bits 17:12. Reading it back returns those fields and 0 in all other bits.
- R3: Offset 0x10 holds the 32-bit throttle value and reads back the value written.
- R4: Offset 0x18 returns the parameter `BUS_PERIOD_NS`, which defaults to 4. Writes to it have no effect.
- R5: A control write with bit 26 set reloads the interval counter. The first request appears N clock cycles after the write edge, where N is the throttle value.
- R6: A throttle value of 0 behaves as 1: one request per clock period.
- R7: While `irq_req` is high, `irq_num` equals number | (priority << 2), kept to 6 bits.
- R8: `irq_req` stays high until a cycle with `irq_ack` high, and drops after that edge unless a new interval ended on the same edge. The counter does not pause, so the next request comes N cycles after the previous one.
- R9: A control write with bit 26 clear drops `irq_req` at that edge, and no further request is raised.
- R10: Offset 0x14 is a 12-bit countdown loaded from write data bits 11:0. It decrements once per clock while non-zero and holds at 0. Bits 31:12 read as 0.
- R11: Reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_ack | input | 1 | Acknowledge pulse from the interrupt controller |
| irq_req | output | 1 | Interrupt request |
| irq_num | output | 6 | Interrupt number presented with the request, 0 when idle |

## Verification
The assertions take for granted the following:
- each register write is a single-cycle strobe with a stable offset;
- `irq_ack` is a one-cycle pulse;
- reset is held low from time zero until the first edges have passed.

The bench drives every input on the falling edge, and writes through a task that lowers the strobe after one cycle. It pulses acknowledge only after it has seen the request. The expiry-and-acknowledge coincidence is reached only with throttle values of 0 and 1, where the state machine is expected to stay in PEND.

// File: rtl/pit_pkg.sv
package pit_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PEND  = 2'd2
    } pit_state_e;

    localparam logic [7:0] OFF_CTRL   = 8'h00;
    localparam logic [7:0] OFF_THROT  = 8'h10;
    localparam logic [7:0] OFF_CDOWN  = 8'h14;
    localparam logic [7:0] OFF_PERIOD = 8'h18;

    localparam int RUN_BIT    = 26;
    localparam int PRIO_LSB   = 20;
    localparam int NUM_LSB    = 12;
    localparam int PRIO_SHIFT = 2;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 8,
    parameter int CD_W          = 12,
    parameter int NUM_W         = 6,
    parameter int PRIO_W        = 4,
    parameter int BUS_PERIOD_NS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ctl_wr,
    output logic              ctl_run,
    output logic [DATA_W-1:0] throttle,
    output logic [NUM_W-1:0]  irq_code
);
    localparam int SHIFTED_W = PRIO_W + PRIO_SHIFT;

    logic              run_q;
    logic [NUM_W-1:0]  num_q;
    logic [PRIO_W-1:0] prio_q;
    logic [DATA_W-1:0] thr_q;
    logic [CD_W-1:0]   cd_q;
    logic              cd_wr;
    logic              thr_wr;
    logic [SHIFTED_W-1:0] prio_shifted;

    assign ctl_wr  = reg_wr && (reg_addr == ADDR_W'(OFF_CTRL));
    assign thr_wr  = reg_wr && (reg_addr == ADDR_W'(OFF_THROT));
    assign cd_wr   = reg_wr && (reg_addr == ADDR_W'(OFF_CDOWN));
    assign ctl_run = reg_wdata[RUN_BIT];
    assign throttle = thr_q;

    assign prio_shifted = {prio_q, {PRIO_SHIFT{1'b0}}};
    assign irq_code     = num_q | NUM_W'(prio_shifted);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            num_q  <= '0;
            prio_q <= '0;
            thr_q  <= '0;
        end else begin
            if (ctl_wr) begin
                run_q  <= reg_wdata[RUN_BIT];
                num_q  <= reg_wdata[NUM_LSB +: NUM_W];
                prio_q <= reg_wdata[PRIO_LSB +: PRIO_W];
            end
            if (thr_wr) begin
                thr_q <= reg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_q <= '0;
        end else if (cd_wr) begin
            cd_q <= reg_wdata[CD_W-1:0];
        end else if (cd_q != '0) begin
            cd_q <= cd_q - 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFF_CTRL)) begin
            reg_rdata[RUN_BIT]               = run_q;
            reg_rdata[PRIO_LSB +: PRIO_W]    = prio_q;
            reg_rdata[NUM_LSB +: NUM_W]      = num_q;
        end else if (reg_addr == ADDR_W'(OFF_THROT)) begin
            reg_rdata = thr_q;
        end else if (reg_addr == ADDR_W'(OFF_CDOWN)) begin
            reg_rdata[CD_W-1:0] = cd_q;
        end else if (reg_addr == ADDR_W'(OFF_PERIOD)) begin
            reg_rdata = DATA_W'(BUS_PERIOD_NS);
        end
    end

    // R10: the countdown steps down by one per clock unless reloaded
    assert_cdown_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_q != '0 && !cd_wr) |=> (cd_q == $past(cd_q) - 1'b1));
    // R10: the countdown holds at zero
    assert_cdown_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_q == '0 && !cd_wr) |=> (cd_q == '0));
endmodule

// File: rtl/pit_interval.sv
module pit_interval #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              running,
    input  logic [DATA_W-1:0] throttle,
    output logic              elapse
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] reload;

    assign reload = (throttle == '0) ? ONE : throttle;
    assign elapse = running && !load && (cnt_q == ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (running) begin
            if (cnt_q == ONE) begin
                cnt_q <= reload;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // R6: a running counter never sits at zero, so a zero throttle cannot stall it
    assert_cnt_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !load) |-> (cnt_q != '0));
endmodule

// File: rtl/pit_fsm.sv
module pit_fsm
    import pit_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       ctl_run,
    input  logic       elapse,
    input  logic       irq_ack,
    output pit_state_e state,
    output logic       irq_req
);
    pit_state_e state_q;
    pit_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (ctl_wr) begin
            state_d = ctl_run ? ST_COUNT : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_COUNT: state_d = elapse ? ST_PEND : ST_COUNT;
                ST_PEND:  state_d = (irq_ack && !elapse) ? ST_COUNT : ST_PEND;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        state   = state_q;
        irq_req = (state_q == ST_PEND);
    end

    // R8: a pending request is held until acknowledged
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack && !ctl_wr) |=> irq_req);
    // R8: an acknowledge with no fresh expiry retires the request
    assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && !elapse && !ctl_wr) |=> !irq_req);
    // R9: a halt write removes the request at once
    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_run) |=> !irq_req);
    // R9: a stopped timer stays silent
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !ctl_wr) |=> !irq_req);
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 8,
    parameter int CD_W          = 12,
    parameter int NUM_W         = 6,
    parameter int PRIO_W        = 4,
    parameter int BUS_PERIOD_NS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [NUM_W-1:0]  irq_num
);
    logic              ctl_wr;
    logic              ctl_run;
    logic [DATA_W-1:0] throttle;
    logic [NUM_W-1:0]  irq_code;
    logic              elapse;
    logic              running;
    pit_state_e        state;

    pit_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CD_W(CD_W),
        .NUM_W(NUM_W), .PRIO_W(PRIO_W), .BUS_PERIOD_NS(BUS_PERIOD_NS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_wr(ctl_wr),
        .ctl_run(ctl_run), .throttle(throttle), .irq_code(irq_code)
    );

    assign running = (state != ST_IDLE);

    pit_interval #(.DATA_W(DATA_W)) u_interval (
        .clk(clk), .rst_n(rst_n), .load(ctl_wr && ctl_run),
        .running(running), .throttle(throttle), .elapse(elapse)
    );

    pit_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_run(ctl_run),
        .elapse(elapse), .irq_ack(irq_ack), .state(state), .irq_req(irq_req)
    );

    assign irq_num = irq_req ? irq_code : '0;

    // R7: the presented number does not change while a request is held
    assert_num_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !ctl_wr && !irq_ack) |=> $stable(irq_num));
endmodule

// File: tb/tb_pit_timer.sv
module tb_pit_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [5:0]  irq_num;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    pit_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_num(irq_num)
    );

    localparam int VEC_N = 6;
    localparam logic [31:0] V_THR  [VEC_N] = '{32'd3, 32'd1, 32'd0, 32'd7, 32'd12, 32'd2};
    localparam logic [5:0]  V_NUM  [VEC_N] = '{6'h05, 6'h21, 6'h3F, 6'h00, 6'h12, 6'h2A};
    localparam logic [3:0]  V_PRIO [VEC_N] = '{4'h0, 4'hA, 4'hF, 4'h5, 4'h3, 4'h0};
    localparam logic [5:0]  V_EXP  [VEC_N] = '{6'h05, 6'h29, 6'h3F, 6'h14, 6'h1E, 6'h2A};

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_req(output int c);
        c = 0;
        while (!irq_req && c < 200) begin
            @(negedge clk);
            c++;
        end
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int c1, c2, ivl;
        bit seen;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(irq_req == 1'b0, "R1 irq_req", irq_req, 0);
        rd(8'h00, d); check(d == 0, "R1 ctrl", d, 0);
        rd(8'h10, d); check(d == 0, "R1 throttle", d, 0);
        rd(8'h14, d); check(d == 0, "R1 countdown", d, 0);

        // R4: bus period constant, writes ignored
        rd(8'h18, d); check(d == 32'd4, "R4 period", d, 4);
        wr(8'h18, 32'h1234_5678);
        rd(8'h18, d); check(d == 32'd4, "R4 period after write", d, 4);

        // R11: unmapped offset
        rd(8'h04, d); check(d == 0, "R11 unmapped", d, 0);

        // R3: throttle readback
        wr(8'h10, 32'hDEAD_BEEF);
        rd(8'h10, d); check(d == 32'hDEAD_BEEF, "R3 throttle", d, 32'hDEAD_BEEF);

        // R2: control field readback, then halt
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); check(d == 32'h04F3_F000, "R2 ctrl fields", d, 32'h04F3_F000);
        wr(8'h00, 32'h0);
        rd(8'h00, d); check(d == 0, "R2 ctrl cleared", d, 0);

        // Vector table: R5 R6 R7 R8 R9
        for (int i = 0; i < VEC_N; i++) begin
            ivl = (V_THR[i] == 0) ? 1 : int'(V_THR[i]);
            wr(8'h10, V_THR[i]);
            wr(8'h00, (32'd1 << 26) | (32'(V_PRIO[i]) << 20) | (32'(V_NUM[i]) << 12));
            wait_req(c1);
            check(irq_req && c1 == ivl, (V_THR[i] == 0) ? "R6 zero throttle" : "R5 first interval", c1, ivl);
            check(irq_num == V_EXP[i], "R7 irq_num", irq_num, V_EXP[i]);
            ack_pulse();
            if (ivl >= 2) check(irq_req == 1'b0, "R8 drop after ack", irq_req, 0);
            wait_req(c2);
            check(irq_req && c2 == ivl - 1, "R8 no drift", c2, ivl - 1);
            wr(8'h00, 32'h0);
            check(irq_req == 1'b0, "R9 halt immediate", irq_req, 0);
            seen = 1'b0;
            repeat (3 * ivl + 2) begin
                @(negedge clk);
                if (irq_req) seen = 1'b1;
            end
            check(!seen, "R9 silent after halt", seen, 0);
        end

        // R8: request held while not acknowledged
        wr(8'h10, 32'd5);
        wr(8'h00, (32'd1 << 26) | (32'h11 << 12));
        wait_req(c1);
        seen = 1'b1;
        repeat (12) begin
            @(negedge clk);
            if (!irq_req) seen = 1'b0;
        end
        check(seen, "R8 held without ack", seen, 1);
        ack_pulse();
        wr(8'h00, 32'h0);

        // R5: re-arm reloads the counter mid-interval
        wr(8'h10, 32'd6);
        wr(8'h00, 32'd1 << 26);
        repeat (3) @(negedge clk);
        wr(8'h00, 32'd1 << 26);
        wait_req(c1);
        check(irq_req && c1 == 6, "R5 re-arm reload", c1, 6);
        wr(8'h00, 32'h0);

        // R10: countdown
        wr(8'h14, 32'hFFFF_ABCD);
        rd(8'h14, d); check(d == 32'h0000_0BCD, "R10 countdown load", d, 32'hBCD);
        repeat (10) @(negedge clk);
        rd(8'h14, d); check(d == 32'h0000_0BC3, "R10 countdown step", d, 32'hBC3);
        wr(8'h14, 32'd3);
        repeat (6) @(negedge clk);
        rd(8'h14, d); check(d == 0, "R10 countdown floor", d, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule